// File: doc/BRIEF.md
# Serial line status event register

This block keeps sticky event flags for one serial channel. Two flags record level changes on the clear-to-send and carrier-detect modem inputs. Two more flags record receiver conditions, and their meaning depends on the channel's framing mode. In asynchronous mode they record the start and end of a break. In bit-oriented synchronous (HDLC) mode they record an abort and the start of idle. In byte-oriented synchronous mode they are unused and stay at zero. The receiver's detectors are outside the block. Only their one-cycle event pulses enter it.

Software reads the four flags as a nibble and acknowledges them by writing ones to their positions. An interrupt line is high whenever any flag is set. The modem inputs may be asynchronous to the clock, so they are resynchronized inside the block before edges are detected. A mode switch discards the mode-dependent flags, so a stale event cannot be read under the wrong meaning.

Top module: `slsr_top`

## Requirements
- R1: While `rst` is high, and after it falls, `rd_data` is 4'b0000 and `irq` is 0. A modem input that is steady through reset produces no flag.
- R2: Any toggle of `cts_in` sets `rd_data[3]`. The flag is visible after the third rising clock edge that follows the toggle. It stays set until it is cleared by a write.
- R3: Any toggle of `dcd_in` sets `rd_data[2]`, with the same latency and the same sticky behaviour as R2.
- R4: In asynchronous mode (`mode` = 2'b00), a pulse on `evt_brk_start` sets `rd_data[1]` and a pulse on `evt_brk_end` sets `rd_data[0]`. Each flag is visible after the edge that samples the pulse.
- R5: In bit synchronous mode (`mode` = 2'b10), a pulse on `evt_abort` sets `rd_data[1]` and a pulse on `evt_idle` sets `rd_data[0]`. Each flag is visible after the edge that samples the pulse.
- R6: In byte synchronous mode (`mode` = 2'b01) and in the unused code 2'b11, `rd_data[1:0]` reads 2'b00. Event pulses and writes do not change these bits.
- R7: A cycle with `wr_en` high clears every flag whose `wr_data` bit is 1. Flags whose `wr_data` bit is 0 are left unchanged.
- R8: If a flag's set event and its clear-by-write fall in the same cycle, the flag ends up set.
- R9: A change of `mode` clears `rd_data[1:0]` at that edge. Pulses that belong to the other framing mode are ignored: abort and idle in asynchronous mode, break start and break end in bit synchronous mode.
- R10: `irq` equals the OR of the four flags in every cycle.
- R11: The detection of R2 and R3 behaves the same in all modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_in | input | 1 | Clear-to-send level, not synchronized |
| dcd_in | input | 1 | Carrier-detect level, not synchronized |
| mode | input | 2 | Framing mode: 00 async, 01 byte sync, 10 bit sync, 11 unused |
| evt_brk_start | input | 1 | Receiver pulse: break began |
| evt_brk_end | input | 1 | Receiver pulse: break ended |
| evt_abort | input | 1 | Receiver pulse: HDLC abort seen |
| evt_idle | input | 1 | Receiver pulse: idle began |
| wr_en | input | 1 | Write strobe for clear-by-one |
| wr_data | input | 4 | Mask of flags to clear |
| rd_data | output | 4 | Flags: [3] CTS change, [2] DCD change, [1] break start or abort, [0] break end or idle |
| irq | output | 1 | OR of the flags |

## Verification
The following results show up one edge after the inputs that cause them: event pulses, writes and mode changes all act at the next rising edge. A modem-line toggle needs three edges: two synchronizer stages and the comparison with the previous sample. The interrupt changes in the same cycle as the flags.

The bench drives inputs on falling edges and compares on falling edges against a reference model that keeps a queue of raw line samples. Each directed check is placed on the falling edge where its latency says the result must first appear, and one cycle earlier where the absence of a flag is the point.

// File: rtl/slsr_pkg.sv
package slsr_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_BYTE  = 2'b01,
    MODE_BIT   = 2'b10,
    MODE_RSVD  = 2'b11
  } line_mode_e;

  localparam int STAT_W  = 4;
  localparam int BIT_CTS = 3;
  localparam int BIT_DCD = 2;
  localparam int BIT_RX1 = 1;
  localparam int BIT_RX0 = 0;
  localparam int LINES   = 2;
endpackage

// File: rtl/slsr_sync.sv
module slsr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= d;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/slsr_edge.sv
module slsr_edge #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] chg
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk) begin
    prev <= lvl;
  end

  assign chg = rst ? '0 : (lvl ^ prev);
endmodule

// File: rtl/slsr_evt_map.sv
module slsr_evt_map
  import slsr_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       evt_brk_start,
  input  logic       evt_brk_end,
  input  logic       evt_abort,
  input  logic       evt_idle,
  output logic [1:0] set_rx
);
  always_comb begin
    case (line_mode_e'(mode))
      MODE_ASYNC: set_rx = {evt_brk_start, evt_brk_end};
      MODE_BIT:   set_rx = {evt_abort, evt_idle};
      default:    set_rx = 2'b00;
    endcase
  end
endmodule

// File: rtl/slsr_top.sv
module slsr_top
  import slsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cts_in,
  input  logic              dcd_in,
  input  logic [1:0]        mode,
  input  logic              evt_brk_start,
  input  logic              evt_brk_end,
  input  logic              evt_abort,
  input  logic              evt_idle,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq
);
  logic [LINES-1:0]  line_sync;
  logic [LINES-1:0]  line_chg;
  logic [1:0]        set_rx;
  logic [1:0]        mode_q;
  logic              mode_chg;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] stat_d;
  logic              irq_q;

  slsr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cts_in, dcd_in}),
    .q   (line_sync)
  );

  slsr_edge #(.WIDTH(LINES)) u_edge (
    .clk (clk),
    .rst (rst),
    .lvl (line_sync),
    .chg (line_chg)
  );

  slsr_evt_map u_map (
    .mode          (mode),
    .evt_brk_start (evt_brk_start),
    .evt_brk_end   (evt_brk_end),
    .evt_abort     (evt_abort),
    .evt_idle      (evt_idle),
    .set_rx        (set_rx)
  );

  assign mode_chg = (mode != mode_q);
  assign set_vec  = {line_chg, set_rx};
  assign clr_vec  = wr_en ? wr_data : '0;

  always_comb begin
    stat_d = (stat_q & ~clr_vec) | set_vec;
    if (mode_chg) stat_d[BIT_RX1:BIT_RX0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
      mode_q <= mode;
    end else begin
      stat_q <= stat_d;
      irq_q  <= |stat_d;
      mode_q <= mode;
    end
  end

  assign rd_data = stat_q;
  assign irq     = irq_q;
endmodule

// File: rtl/slsr_chk.sv
module slsr_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       evt_brk_start,
  input logic       evt_abort,
  input logic       wr_en,
  input logic [3:0] wr_data,
  input logic [3:0] rd_data,
  input logic       irq
);
  // R10
  a_r10_irq_or: assert property (@(posedge clk) disable iff (rst)
    irq == (|rd_data));

  // R6
  a_r6_byte_zero: assert property (@(posedge clk) disable iff (rst)
    (mode[0] && $stable(mode)) |=> (rd_data[1:0] == 2'b00));

  // R9
  a_r9_mode_clear: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |=> (rd_data[1:0] == 2'b00));

  // R2
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (rd_data[3] && !(wr_en && wr_data[3])) |=> rd_data[3]);

  // R8
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && $stable(mode) && evt_brk_start) |=> rd_data[1]);

  // R5
  a_r5_abort: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && $stable(mode) && evt_abort) |=> rd_data[1]);
endmodule

bind slsr_top slsr_chk u_chk (.*);

// File: tb/slsr_top_bench.sv
module slsr_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cts_in = 1'b1, dcd_in = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       evt_brk_start = 0, evt_brk_end = 0, evt_abort = 0, evt_idle = 0;
  logic       wr_en = 0;
  logic [3:0] wr_data = 4'h0;
  logic [3:0] rd_data;
  logic       irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  slsr_top u_slsr_top (.*);

  // reference model
  logic       cq[$];
  logic       dq[$];
  logic [3:0] m_stat = 4'h0;
  logic [1:0] m_mode_prev = 2'b00;
  bit         model_live = 0;

  always @(posedge clk) begin
    logic [3:0] nxt;
    if (rst) begin
      cq = {cts_in, cts_in, cts_in, cts_in};
      dq = {dcd_in, dcd_in, dcd_in, dcd_in};
      m_stat = 4'h0;
      m_mode_prev = mode;
    end else begin
      cq.push_back(cts_in); void'(cq.pop_front());
      dq.push_back(dcd_in); void'(dq.pop_front());
      nxt = m_stat;
      if (wr_en) nxt = nxt & ~wr_data;
      if (cq[0] != cq[1]) nxt[3] = 1'b1;
      if (dq[0] != dq[1]) nxt[2] = 1'b1;
      if (mode == 2'b00) begin
        if (evt_brk_start) nxt[1] = 1'b1;
        if (evt_brk_end)   nxt[0] = 1'b1;
      end else if (mode == 2'b10) begin
        if (evt_abort) nxt[1] = 1'b1;
        if (evt_idle)  nxt[0] = 1'b1;
      end
      if (mode != m_mode_prev) nxt[1:0] = 2'b00;
      m_mode_prev = mode;
      m_stat = nxt;
    end
  end

  always @(negedge clk) begin
    if (model_live && !done) begin
      n_run++;
      if (rd_data !== m_stat || irq !== (|m_stat)) begin
        n_fail++;
        if (irq !== (|m_stat))
          $display("FAIL R10 model: irq=%b expected %b", irq, |m_stat);
        else if (rd_data[3] !== m_stat[3])
          $display("FAIL R2 model: rd_data=%b expected %b", rd_data, m_stat);
        else if (rd_data[2] !== m_stat[2])
          $display("FAIL R3 model: rd_data=%b expected %b", rd_data, m_stat);
        else
          $display("FAIL R4 model: rd_data=%b expected %b", rd_data, m_stat);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    n_run++;
    if (rd_data !== exp || irq !== (|exp)) begin
      n_fail++;
      $display("FAIL %s: rd_data=%b irq=%b expected %b irq=%b", tag, rd_data, irq, exp, |exp);
    end
  endtask

  task automatic wr(input logic [3:0] m);
    wr_en = 1; wr_data = m; tick(1); wr_en = 0; wr_data = 4'h0;
  endtask

  task automatic pulse(input logic bs, be, ab, id);
    evt_brk_start = bs; evt_brk_end = be; evt_abort = ab; evt_idle = id;
    tick(1);
    evt_brk_start = 0; evt_brk_end = 0; evt_abort = 0; evt_idle = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    chk("R1 during reset", 4'b0000);
    rst = 0; model_live = 1;
    tick(5);
    chk("R1 after reset", 4'b0000);

    cts_in = 0; tick(2);
    chk("R2 latency not yet", 4'b0000);
    tick(1);
    chk("R2 falling toggle", 4'b1000);
    wr(4'b0111);
    chk("R7 zero mask keeps", 4'b1000);
    wr(4'b1000);
    chk("R7 clear", 4'b0000);
    cts_in = 1; tick(3);
    chk("R2 rising toggle", 4'b1000);
    wr(4'b1000);

    mode = 2'b01; tick(1);
    dcd_in = 1; tick(3);
    chk("R3 R11 dcd in byte mode", 4'b0100);
    wr(4'b0100);
    mode = 2'b10; tick(1);
    cts_in = 0; tick(3);
    chk("R11 cts in bit mode", 4'b1000);
    wr(4'b1000);
    chk("R7 cleared", 4'b0000);

    pulse(0, 0, 1, 0);
    chk("R5 abort", 4'b0010);
    pulse(0, 0, 0, 1);
    chk("R5 idle", 4'b0011);
    pulse(1, 1, 0, 0);
    chk("R9 break ignored in bit mode", 4'b0011);
    wr(4'b0011);
    chk("R7 clear rx", 4'b0000);

    mode = 2'b00; tick(1);
    pulse(1, 0, 0, 0);
    chk("R4 break start", 4'b0010);
    pulse(0, 0, 1, 1);
    chk("R9 abort idle ignored in async", 4'b0010);
    pulse(0, 1, 0, 0);
    chk("R4 break end", 4'b0011);

    mode = 2'b10; tick(1);
    chk("R9 mode change clears", 4'b0000);
    pulse(0, 0, 1, 0);
    chk("R5 abort again", 4'b0010);
    mode = 2'b00; tick(1);
    chk("R9 back to async clears", 4'b0000);

    mode = 2'b01; tick(1);
    pulse(1, 1, 1, 1);
    chk("R6 byte mode events ignored", 4'b0000);
    wr(4'b0011);
    chk("R6 byte mode write no effect", 4'b0000);
    mode = 2'b11; tick(1);
    pulse(1, 1, 1, 1);
    chk("R6 unused code ignored", 4'b0000);

    mode = 2'b00; tick(1);
    pulse(1, 0, 0, 0);
    evt_brk_start = 1; wr_en = 1; wr_data = 4'b0010; tick(1);
    evt_brk_start = 0; wr_en = 0; wr_data = 4'h0;
    chk("R8 set wins over clear", 4'b0010);
    wr(4'b1111);
    chk("R7 clear all", 4'b0000);

    for (int i = 0; i < 600; i++) begin
      cts_in = ($urandom_range(0, 7) == 0) ? ~cts_in : cts_in;
      dcd_in = ($urandom_range(0, 7) == 0) ? ~dcd_in : dcd_in;
      if ($urandom_range(0, 40) == 0) mode = 2'($urandom_range(0, 3));
      evt_brk_start = ($urandom_range(0, 9) == 0);
      evt_brk_end   = ($urandom_range(0, 9) == 0);
      evt_abort     = ($urandom_range(0, 9) == 0);
      evt_idle      = ($urandom_range(0, 9) == 0);
      wr_en         = ($urandom_range(0, 5) == 0);
      wr_data       = 4'($urandom_range(0, 15));
      tick(1);
    end
    evt_brk_start = 0; evt_brk_end = 0; evt_abort = 0; evt_idle = 0; wr_en = 0;
    tick(2);
    finish_run();
  end
endmodule